// File: doc/BRIEF.md
# Power Mode Sequencer

This block is the operating-state controller of a power management unit. It moves between five states: power-up, normal, sleep, reboot request and hard reboot. Its inputs are a software sleep command, a thermal-fault flag, an undervoltage-lockout flag, a resume pin, an active-low hot-reset pin and a software reboot bit. Its outputs are an active-low "no power" indication, one enable per switchable supply, an always-on RTC supply enable, a one-cycle register-reset pulse, and a reboot-cause flag that the host clears through a handshake.

The state entered on leaving sleep depends on what caused the sleep. A thermal fault can only be left through a full supply removal, which restarts power-up. Any other cause is left through a timed high-low-high request on the resume pin, which returns to normal operation.

A reboot can be requested by software or by the hot-reset pin. A pin request counts only when the low level lasts long enough. The block then holds a fixed wait and a fixed supply re-enable step before it returns to normal operation. The cause flag records whether the last return to normal followed a pin-triggered reboot. The host clears the flag with a clear input that it must release again before the flag can next be set. All durations are parameters counted in clock cycles. The two pins pass through two-flop synchronizers.

Top module: `pwr_seq`

## Requirements
- R1: While reset is asserted and in the first cycles after it, `state_o` reads 0 (power-up), `nopower_no` is low, all `sup_en_o` bits are 1 and `reg_rst_o` and `cause_hot_o` are 0. After ON_CYC cycles the block enters normal (`state_o` = 1) and `nopower_no` goes high. The state codes are 0 power-up, 1 normal, 2 sleep, 3 reboot request and 4 hard reboot.
- R2: In sleep (code 2) every `sup_en_o` bit is 0, `nopower_no` is low and `rtc_en_o` stays 1.
- R3: `reg_rst_o` is high for exactly one cycle, the first cycle of each sleep, and is low at all other times.
- R4: A sleep entered while `therm_flt_i` was high ignores resume requests. It ends only when `uvlo_i` is high, and the next state is power-up (code 0).
- R5: A sleep entered through `sleep_cmd_i` without a thermal fault ignores `uvlo_i`. It ends only on a qualified resume request, and the next state is normal.
- R6: A qualified resume request is the resume pin high for at least RES_H cycles, then low for at least RES_L cycles, then high for at least RES_H cycles. A shorter low phase does not end sleep.
- R7: A hot-reset low level requests a reboot only after HOT_MIN+1 consecutive low cycles following synchronization. A shorter low pulse has no effect.
- R8: The reboot request state (code 3) is entered only from normal, on `soft_rst_i` or on a qualified hot-reset low. Hot-reset and `soft_rst_i` have no effect during sleep.
- R9: The reboot request state lasts exactly WAIT_CYC cycles with `nopower_no` low. Hard reboot (code 4) follows for exactly ON_CYC cycles, and then normal.
- R10: `cause_hot_o` becomes 1 on entering normal after a reboot that hot-reset triggered. It becomes 0 on entering normal after power-up, after sleep, or after a software-triggered reboot.
- R11: While `cause_clr_i` is 1, `cause_hot_o` is 0, and a hot-reset reboot that completes during that time does not set it. After `cause_clr_i` returns to 0 the flag stays 0 until the next hot-reset reboot.
- R12: In normal, when several requests arrive in the same cycle, a thermal fault wins over the sleep command, and the sleep command wins over any reboot request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; places the block in power-up |
| sleep_cmd_i | input | 1 | Software sleep command |
| therm_flt_i | input | 1 | Thermal fault flag; forces sleep from normal |
| uvlo_i | input | 1 | All input supplies and battery removed |
| resume_i | input | 1 | Asynchronous resume pin |
| hotrst_ni | input | 1 | Asynchronous active-low hot-reset pin |
| soft_rst_i | input | 1 | Software reboot register bit |
| cause_clr_i | input | 1 | Host clear for the reboot-cause flag |
| nopower_no | output | 1 | Low whenever the block is not in normal |
| sup_en_o | output | N_SUP | Switchable supply enables |
| rtc_en_o | output | 1 | Always-on RTC supply enable |
| reg_rst_o | output | 1 | One-cycle reset for the bus interface and register bits on sleep entry |
| cause_hot_o | output | 1 | Last return to normal followed a hot-reset reboot |
| state_o | output | 3 | Current state code |

## Verification
A vector table runs scenario sequences from normal and checks the resulting state and cause flag after each. Software reboots and pin reboots are run next to each other, which separates the cause flag's two outcomes. A long and a short hot-reset pulse separate the width filter's accept and reject cases. Sleep is entered both by command and by thermal fault, and each is then offered both exit stimuli, which shows that the exit path depends on the cause. Directed cases count the cycles of the reboot wait and the hard-reboot step, offer a resume sequence with a low phase that is too short, combine simultaneous requests, and walk the clear handshake of the cause flag.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_PWRUP  = 3'd0,
    ST_NORMAL = 3'd1,
    ST_SLEEP  = 3'd2,
    ST_RBREQ  = 3'd3,
    ST_HARDRB = 3'd4
  } pwr_state_e;

  typedef enum logic [1:0] {
    RP_HI1 = 2'd0,
    RP_LO  = 2'd1,
    RP_HI2 = 2'd2
  } res_phase_e;
endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= {2{RST_VAL[g]}};
      else         ff_q <= {ff_q[0], d_i[g]};
    end
    assign q_o[g] = ff_q[1];
  end
endmodule

// File: rtl/pwr_seq_lowfilt.sv
module pwr_seq_lowfilt #(
  parameter int unsigned MIN_LOW = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic qual_o
);
  localparam int unsigned CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_LOW);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (lvl_i)        cnt_q <= '0;
    else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = !lvl_i && (cnt_q == CMAX);

  AST_QUAL_AFTER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_o |-> !$past(lvl_i)); // R7
endmodule

// File: rtl/pwr_seq_resume.sv
module pwr_seq_resume
  import pwr_seq_pkg::*;
#(
  parameter int unsigned HI_MIN = 5,
  parameter int unsigned LO_MIN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic lvl_i,
  output logic done_o
);
  localparam int unsigned MAXC = (HI_MIN > LO_MIN) ? HI_MIN : LO_MIN;
  localparam int unsigned CW   = $clog2(MAXC + 2);
  localparam logic [CW-1:0] CSAT = CW'(MAXC + 1);
  localparam logic [CW-1:0] HI_C = CW'(HI_MIN);
  localparam logic [CW-1:0] HI_L = CW'(HI_MIN - 1);
  localparam logic [CW-1:0] LO_C = CW'(LO_MIN);

  res_phase_e    ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc = (cnt_q == CSAT) ? cnt_q : cnt_q + 1'b1;
  assign done_o  = en_i && (ph_q == RP_HI2) && lvl_i && (cnt_q >= HI_L);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (!en_i) begin
      ph_d  = RP_HI1;
      cnt_d = '0;
    end else begin
      unique case (ph_q)
        RP_HI1: begin
          if (lvl_i)              cnt_d = cnt_inc;
          else if (cnt_q >= HI_C) begin ph_d = RP_LO; cnt_d = CW'(1); end
          else                    cnt_d = '0;
        end
        RP_LO: begin
          if (!lvl_i)             cnt_d = cnt_inc;
          else if (cnt_q >= LO_C) begin ph_d = RP_HI2; cnt_d = CW'(1); end
          else                    begin ph_d = RP_HI1; cnt_d = CW'(1); end
        end
        RP_HI2: begin
          if (done_o)             begin ph_d = RP_HI1; cnt_d = '0; end
          else if (lvl_i)         cnt_d = cnt_inc;
          else                    begin ph_d = RP_HI1; cnt_d = '0; end
        end
        default: begin ph_d = RP_HI1; cnt_d = '0; end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= RP_HI1;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  AST_HI2_NEEDS_LOW_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == RP_HI2) && ($past(ph_q) != RP_HI2) |-> $past(!lvl_i) || $past(ph_q) == RP_LO); // R6
  AST_DONE_ONLY_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(en_i)); // R6
endmodule

// File: rtl/pwr_seq_cause.sv
module pwr_seq_cause (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nrm_entry_i,
  input  logic hot_src_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          flag_q <= 1'b0;
    else if (clr_i)       flag_q <= 1'b0;
    else if (nrm_entry_i) flag_q <= hot_src_i;
  end

  assign flag_o = flag_q && !clr_i;

  AST_FLAG_SET_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(nrm_entry_i && hot_src_i && !clr_i)); // R10
  AST_CLR_DROPS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> !flag_q); // R11
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned N_SUP    = 4,
  parameter int unsigned ON_CYC   = 6,
  parameter int unsigned WAIT_CYC = 20,
  parameter int unsigned HOT_MIN  = 8,
  parameter int unsigned RES_H    = 5,
  parameter int unsigned RES_L    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_cmd_i,
  input  logic             therm_flt_i,
  input  logic             uvlo_i,
  input  logic             resume_i,
  input  logic             hotrst_ni,
  input  logic             soft_rst_i,
  input  logic             cause_clr_i,
  output logic             nopower_no,
  output logic [N_SUP-1:0] sup_en_o,
  output logic             rtc_en_o,
  output logic             reg_rst_o,
  output logic             cause_hot_o,
  output logic [2:0]       state_o
);
  localparam int unsigned TMAX = (ON_CYC > WAIT_CYC) ? ON_CYC : WAIT_CYC;
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] ON_LAST   = TW'(ON_CYC - 1);
  localparam logic [TW-1:0] WAIT_LAST = TW'(WAIT_CYC - 1);

  pwr_state_e    state_q, state_d;
  logic [TW-1:0] tmr_q;
  logic          therm_q, rb_hot_q, reg_rst_q;
  logic          hot_s, res_s, hot_qual, res_done;
  logic          timed, nrm_entry, sleep_entry;

  pwr_seq_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({hotrst_ni, resume_i}),
    .q_o   ({hot_s, res_s})
  );

  pwr_seq_lowfilt #(.MIN_LOW(HOT_MIN)) u_hotfilt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (hot_s),
    .qual_o(hot_qual)
  );

  pwr_seq_resume #(.HI_MIN(RES_H), .LO_MIN(RES_L)) u_resume (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (state_q == ST_SLEEP),
    .lvl_i (res_s),
    .done_o(res_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PWRUP:  if (tmr_q == ON_LAST) state_d = ST_NORMAL;
      ST_NORMAL: begin
        if (therm_flt_i || sleep_cmd_i)  state_d = ST_SLEEP;
        else if (hot_qual || soft_rst_i) state_d = ST_RBREQ;
      end
      ST_SLEEP: begin
        if (therm_q) begin
          if (uvlo_i) state_d = ST_PWRUP;
        end else if (res_done) begin
          state_d = ST_NORMAL;
        end
      end
      ST_RBREQ:  if (tmr_q == WAIT_LAST) state_d = ST_HARDRB;
      ST_HARDRB: if (tmr_q == ON_LAST) state_d = ST_NORMAL;
      default:   state_d = ST_PWRUP;
    endcase
  end

  assign timed       = (state_q == ST_PWRUP) || (state_q == ST_RBREQ) || (state_q == ST_HARDRB);
  assign nrm_entry   = (state_d == ST_NORMAL) && (state_q != ST_NORMAL);
  assign sleep_entry = (state_d == ST_SLEEP) && (state_q != ST_SLEEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_PWRUP;
      tmr_q     <= '0;
      therm_q   <= 1'b0;
      rb_hot_q  <= 1'b0;
      reg_rst_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      tmr_q     <= (state_d != state_q || !timed) ? '0 : tmr_q + 1'b1;
      reg_rst_q <= sleep_entry;
      if (sleep_entry) therm_q <= therm_flt_i;
      if (state_d == ST_RBREQ && state_q == ST_NORMAL) rb_hot_q <= hot_qual;
    end
  end

  pwr_seq_cause u_cause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .nrm_entry_i(nrm_entry),
    .hot_src_i  ((state_q == ST_HARDRB) && rb_hot_q),
    .clr_i      (cause_clr_i),
    .flag_o     (cause_hot_o)
  );

  assign nopower_no = (state_q == ST_NORMAL);
  assign sup_en_o   = {N_SUP{state_q != ST_SLEEP}};
  assign rtc_en_o   = 1'b1;
  assign reg_rst_o  = reg_rst_q;
  assign state_o    = state_q;

  AST_RBREQ_FROM_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RBREQ) && ($past(state_q) != ST_RBREQ) |-> $past(state_q) == ST_NORMAL); // R8
  AST_REGRST_IN_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rst_o |-> (state_q == ST_SLEEP) && ($past(state_q) != ST_SLEEP)); // R3
  AST_REGRST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rst_o |=> !reg_rst_o); // R3
  AST_THERM_EXIT_PWRUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_SLEEP) && (state_q != ST_SLEEP) && $past(therm_q) |-> state_q == ST_PWRUP); // R4
  AST_CMD_EXIT_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_SLEEP) && (state_q != ST_SLEEP) && !$past(therm_q) |-> state_q == ST_NORMAL); // R5
  AST_WAIT_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HARDRB) && ($past(state_q) == ST_RBREQ) |-> $past(tmr_q) == WAIT_LAST); // R9
  AST_THERM_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_NORMAL) && $past(therm_flt_i) |-> (state_q == ST_SLEEP) && therm_q); // R12
endmodule

// File: tb/pwr_seq_tb.sv
module pwr_seq_tb;
  localparam int N_SUP = 4, ON_CYC = 6, WAIT_CYC = 20, HOT_MIN = 8, RES_H = 5, RES_L = 5;
  localparam int SETTLE = 80;
  localparam int NV = 11;
  // {act[3:0], len[7:0], exp_state[2:0], exp_flag}
  // act: 1 soft reboot, 2 hot-reset low for len, 3 sleep cmd, 4 thermal, 5 resume seq, 6 uvlo
  localparam logic [15:0] VEC [NV] = '{
    {4'd1, 8'd0,  3'd1, 1'b0},
    {4'd2, 8'd30, 3'd1, 1'b1},
    {4'd2, 8'd3,  3'd1, 1'b1},
    {4'd1, 8'd0,  3'd1, 1'b0},
    {4'd3, 8'd0,  3'd2, 1'b0},
    {4'd5, 8'd0,  3'd1, 1'b0},
    {4'd2, 8'd30, 3'd1, 1'b1},
    {4'd3, 8'd0,  3'd2, 1'b1},
    {4'd5, 8'd0,  3'd1, 1'b0},
    {4'd4, 8'd0,  3'd2, 1'b0},
    {4'd6, 8'd0,  3'd1, 1'b0}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sleep_cmd_i = 1'b0, therm_flt_i = 1'b0, uvlo_i = 1'b0, resume_i = 1'b1;
  logic hotrst_ni = 1'b1, soft_rst_i = 1'b0, cause_clr_i = 1'b0;
  logic nopower_no, rtc_en_o, reg_rst_o, cause_hot_o;
  logic [N_SUP-1:0] sup_en_o;
  logic [2:0] state_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  bit mon_en = 1'b0;
  int n_rb = 0, n_hr = 0, n_np = 0, n_rr = 0;

  always #4 clk_i = ~clk_i;

  pwr_seq #(.N_SUP(N_SUP), .ON_CYC(ON_CYC), .WAIT_CYC(WAIT_CYC), .HOT_MIN(HOT_MIN),
            .RES_H(RES_H), .RES_L(RES_L)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sleep_cmd_i(sleep_cmd_i), .therm_flt_i(therm_flt_i),
    .uvlo_i(uvlo_i), .resume_i(resume_i), .hotrst_ni(hotrst_ni), .soft_rst_i(soft_rst_i),
    .cause_clr_i(cause_clr_i), .nopower_no(nopower_no), .sup_en_o(sup_en_o),
    .rtc_en_o(rtc_en_o), .reg_rst_o(reg_rst_o), .cause_hot_o(cause_hot_o), .state_o(state_o)
  );

  always @(negedge clk_i) begin
    if (mon_en) begin
      if (state_o == 3'd3) n_rb++;
      if (state_o == 3'd4) n_hr++;
      if (!nopower_no)     n_np++;
      if (reg_rst_o)       n_rr++;
    end
  end

  task automatic chk(input logic ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic mon_clear();
    n_rb = 0; n_hr = 0; n_np = 0; n_rr = 0;
  endtask

  task automatic pulse_soft();
    soft_rst_i = 1'b1; cyc(1); soft_rst_i = 1'b0;
  endtask

  task automatic pulse_hot(input int len);
    hotrst_ni = 1'b0; cyc(len); hotrst_ni = 1'b1;
  endtask

  task automatic pulse_sleep();
    sleep_cmd_i = 1'b1; cyc(1); sleep_cmd_i = 1'b0;
  endtask

  task automatic pulse_therm();
    therm_flt_i = 1'b1; cyc(1); therm_flt_i = 1'b0;
  endtask

  task automatic pulse_uvlo();
    uvlo_i = 1'b1; cyc(1); uvlo_i = 1'b0;
  endtask

  task automatic resume_seq(input int lo_len);
    resume_i = 1'b1; cyc(8);
    resume_i = 1'b0; cyc(lo_len);
    resume_i = 1'b1; cyc(8);
  endtask

  task automatic apply(input logic [3:0] act, input int len);
    case (act)
      4'd1: pulse_soft();
      4'd2: pulse_hot(len);
      4'd3: pulse_sleep();
      4'd4: pulse_therm();
      4'd5: resume_seq(8);
      4'd6: pulse_uvlo();
      default: ;
    endcase
  endtask

  initial begin
    int wd = 0;
    while (!finished && wd < 20000) begin
      @(posedge clk_i);
      wd++;
    end
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    cyc(3);
    chk(state_o == 3'd0, "R1 state in reset", state_o, 0);
    chk(!nopower_no && sup_en_o == '1 && rtc_en_o, "R1 outputs in reset", {nopower_no, sup_en_o}, 15);
    chk(!reg_rst_o && !cause_hot_o, "R1 pulse/flag in reset", {reg_rst_o, cause_hot_o}, 0);
    rst_ni = 1'b1;
    cyc(1);
    chk(state_o == 3'd0 && !nopower_no, "R1 power-up after release", state_o, 0);
    cyc(ON_CYC + 3);
    chk(state_o == 3'd1 && nopower_no, "R1 normal after power-up", state_o, 1);
    chk(!cause_hot_o, "R10 flag after power-up", cause_hot_o, 0);

    // vector table: R5 R7 R10 R4
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][15:12], int'(VEC[i][11:4]));
      cyc(SETTLE);
      chk(state_o == VEC[i][3:1], $sformatf("R10/R7/R5/R4 vec %0d state", i), state_o, VEC[i][3:1]);
      chk(cause_hot_o == VEC[i][0], $sformatf("R10 vec %0d flag", i), cause_hot_o, VEC[i][0]);
    end

    // R9 reboot wait and re-enable lengths
    mon_clear(); mon_en = 1'b1;
    pulse_soft();
    cyc(60);
    mon_en = 1'b0;
    chk(n_rb == WAIT_CYC, "R9 reboot wait cycles", n_rb, WAIT_CYC);
    chk(n_hr == ON_CYC, "R9 hard reboot cycles", n_hr, ON_CYC);
    chk(n_np == WAIT_CYC + ON_CYC, "R9 nopower low cycles", n_np, WAIT_CYC + ON_CYC);
    chk(state_o == 3'd1, "R9 back to normal", state_o, 1);

    // R2 R3 sleep outputs and register reset pulse
    mon_clear(); mon_en = 1'b1;
    pulse_sleep();
    cyc(20);
    mon_en = 1'b0;
    chk(n_rr == 1, "R3 reg reset pulse count", n_rr, 1);
    chk(state_o == 3'd2 && sup_en_o == '0, "R2 supplies off in sleep", sup_en_o, 0);
    chk(!nopower_no && rtc_en_o, "R2 nopower low rtc on", {nopower_no, rtc_en_o}, 1);

    // R8 hot-reset and soft bit ignored in sleep
    mon_clear(); mon_en = 1'b1;
    pulse_hot(30); pulse_soft();
    cyc(20);
    chk(state_o == 3'd2, "R8 hot/soft ignored in sleep", state_o, 2);
    // R5 uvlo ignored in commanded sleep
    pulse_uvlo(); cyc(10);
    chk(state_o == 3'd2, "R5 uvlo ignored", state_o, 2);
    // R6 short low phase ignored
    resume_seq(2); cyc(20);
    chk(state_o == 3'd2, "R6 short low ignored", state_o, 2);
    resume_seq(8); cyc(10);
    mon_en = 1'b0;
    chk(state_o == 3'd1, "R6 valid resume exits", state_o, 1);
    chk(n_rb == 0, "R8 no reboot from sleep", n_rb, 0);
    chk(n_rr == 0, "R3 no pulse outside sleep entry", n_rr, 0);

    // R7 short hot pulse ignored at boundary
    mon_clear(); mon_en = 1'b1;
    pulse_hot(HOT_MIN);
    cyc(40);
    mon_en = 1'b0;
    chk(n_rb == 0 && state_o == 3'd1, "R7 pulse of HOT_MIN ignored", n_rb, 0);

    // R4 thermal sleep ignores resume, exits via uvlo to power-up
    pulse_therm();
    cyc(10);
    resume_seq(8); cyc(20);
    chk(state_o == 3'd2, "R4 resume ignored after thermal", state_o, 2);
    pulse_uvlo();
    chk(state_o == 3'd0, "R4 uvlo to power-up", state_o, 0);
    cyc(ON_CYC + 4);
    chk(state_o == 3'd1, "R4 normal after power-up", state_o, 1);

    // R12 priorities
    therm_flt_i = 1'b1; sleep_cmd_i = 1'b1; soft_rst_i = 1'b1;
    cyc(1);
    therm_flt_i = 1'b0; sleep_cmd_i = 1'b0; soft_rst_i = 1'b0;
    cyc(5);
    chk(state_o == 3'd2, "R12 thermal wins", state_o, 2);
    resume_seq(8); cyc(20);
    chk(state_o == 3'd2, "R12 thermal cause kept", state_o, 2);
    pulse_uvlo(); cyc(ON_CYC + 4);
    sleep_cmd_i = 1'b1; soft_rst_i = 1'b1;
    cyc(1);
    sleep_cmd_i = 1'b0; soft_rst_i = 1'b0;
    cyc(5);
    chk(state_o == 3'd2, "R12 sleep over reboot", state_o, 2);
    resume_seq(8); cyc(10);
    chk(state_o == 3'd1, "R12 commanded cause exits by resume", state_o, 1);

    // R11 clear handshake
    pulse_hot(30); cyc(SETTLE);
    chk(cause_hot_o, "R11 flag set before clear", cause_hot_o, 1);
    cause_clr_i = 1'b1; cyc(2);
    chk(!cause_hot_o, "R11 clear forces low", cause_hot_o, 0);
    pulse_hot(30); cyc(SETTLE);
    chk(!cause_hot_o && state_o == 3'd1, "R11 no set while clear high", cause_hot_o, 0);
    cause_clr_i = 1'b0; cyc(5);
    chk(!cause_hot_o, "R11 stays low after release", cause_hot_o, 0);
    pulse_hot(30); cyc(SETTLE);
    chk(cause_hot_o, "R11 set again after release", cause_hot_o, 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule